// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer on a plain register bus with single-cycle access. The system clock first passes a programmable prescaler that divides by P+1 (P is 8 bits). A second stage then divides by 16, 32, 64 or 128. Each tick from that chain steps a 16-bit down-counter.

When the counter runs out, the block reloads it from a separate reload register. Depending on the control bits, it also latches an interrupt flag, drives a fixed-length reset request pulse, or both. Software keeps the system alive by writing a fresh value into the live counter before it runs out. A pending interrupt is cleared by writing 1 to a dedicated clear register.

Top module: `pwdog_top`

## Requirements
- R1: After reset the control register reads 0x8021, the reload register and the live counter read 0x8000, and irq and resetReq are low.
- R2: The registers sit at byte offsets 0x00 (control), 0x04 (reload), 0x08 (live counter) and 0x0C (interrupt clear). Control bits 1, 6 and 7 read as zero whatever is written, and the clear register always reads 0.
- R3: Control bit 5 runs the timer. Bits 15:8 give P, and bits 4:3 select the second-stage divide D (0:/16, 1:/32, 2:/64, 3:/128). Once the timer is started with count N, it expires on exactly the (N+1)·(P+1)·D-th clock edge.
- R4: The tick that finds the counter at zero is the expiry event, and on that event the counter takes the value of the reload register.
- R5: A write to the live counter loads the written value on the next edge. This write takes priority over a tick in the same cycle, so repeated writes keep the timer from expiring.
- R6: While bit 5 is clear, the counter holds its value and the prescaler and divider are held at their start state.
- R7: irq equals the interrupt flag ANDed with control bit 2. Writing 1 to bit 0 of the clear register clears the flag, and writing 0 there leaves it set.
- R8: An expiry sets the interrupt flag only if control bit 2 is set at that moment.
- R9: An expiry with control bit 0 set starts a reset request that stays high for exactly 128 clock cycles, starting at the expiry edge. Clearing bit 0 forces resetReq low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Byte offset of the register being accessed |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr (combinational) |
| irq | output | 1 | Interrupt request, level |
| resetReq | output | 1 | System reset request pulse |

## Verification
The hardest thing to observe from the ports is the exact edge on which expiry happens. That edge depends on the phase of two hidden counters that software cannot read. The bench therefore stops the timer before each run, which returns both the prescaler and the divider to their start state. It then restarts the timer with a single control write and sweeps every divide select across several prescale values and start counts. In each run it checks that irq is still low one edge before the computed expiry and high on that edge.

// File: rtl/pwdog_pkg.sv
package pwdog_pkg;
  parameter int CNT_W     = 16;
  parameter int PRE_W     = 8;
  parameter int DATA_W    = 16;
  parameter int ADDR_W    = 4;
  parameter int DIVSEL_W  = 2;
  parameter int BASE_DIV  = 16;
  parameter int PULSE_LEN = 128;

  localparam int DIV_CNT_W = $clog2(BASE_DIV) + (1 << DIVSEL_W) - 1;
  localparam int PULSE_W   = $clog2(PULSE_LEN + 1);

  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_RELOAD = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_COUNT  = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFS_ICLR   = ADDR_W'(4'hC);

  localparam int BIT_RSTEN = 0;
  localparam int BIT_INTEN = 2;
  localparam int DIV_LSB   = 3;
  localparam int BIT_RUN   = 5;
  localparam int PRE_LSB   = 8;

  localparam logic [DATA_W-1:0] CTRL_MASK  = DATA_W'(16'hFF3D);
  localparam logic [DATA_W-1:0] CTRL_RESET = DATA_W'(16'h8021);
  localparam logic [CNT_W-1:0]  CNT_RESET  = CNT_W'(16'h8000);

  typedef struct packed {
    logic                run;
    logic                rstEn;
    logic [DIVSEL_W-1:0] divSel;
    logic [PRE_W-1:0]    prescale;
    logic                loadCnt;
    logic [CNT_W-1:0]    loadVal;
    logic [CNT_W-1:0]    reload;
  } dpCmd_t;
endpackage

// File: rtl/pwdog_ctrl.sv
module pwdog_ctrl
  import pwdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  output dpCmd_t            cmd,
  output logic              irq
);
  logic [DATA_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  reloadQ;
  logic              flagQ;
  logic selCtrl, selReload, selCount, selIclr, clrReq;

  assign selCtrl   = (busAddr == OFS_CTRL);
  assign selReload = (busAddr == OFS_RELOAD);
  assign selCount  = (busAddr == OFS_COUNT);
  assign selIclr   = (busAddr == OFS_ICLR);
  assign clrReq    = busWe && selIclr && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= CTRL_RESET;
      reloadQ <= CNT_RESET;
    end else if (busWe) begin
      if (selCtrl)   ctrlQ   <= busWdata & CTRL_MASK;
      if (selReload) reloadQ <= busWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          flagQ <= 1'b0;
    else if (expire && ctrlQ[BIT_INTEN]) flagQ <= 1'b1;
    else if (clrReq)                    flagQ <= 1'b0;
  end

  always_comb begin
    cmd.run      = ctrlQ[BIT_RUN];
    cmd.rstEn    = ctrlQ[BIT_RSTEN];
    cmd.divSel   = ctrlQ[DIV_LSB +: DIVSEL_W];
    cmd.prescale = ctrlQ[PRE_LSB +: PRE_W];
    cmd.loadCnt  = busWe && selCount;
    cmd.loadVal  = busWdata[CNT_W-1:0];
    cmd.reload   = reloadQ;
  end

  always_comb begin
    busRdata = '0;
    if (selCtrl)        busRdata = ctrlQ;
    else if (selReload) busRdata = DATA_W'(reloadQ);
    else if (selCount)  busRdata = DATA_W'(count);
  end

  assign irq = flagQ & ctrlQ[BIT_INTEN];

  AST_FLAG_NEEDS_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(expire)); // R8
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !expire) |=> !flagQ); // R7
endmodule

// File: rtl/pwdog_datapath.sv
module pwdog_datapath
  import pwdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             resetReq
);
  logic [PRE_W-1:0]     preCnt;
  logic [DIV_CNT_W-1:0] divCnt;
  logic [DIV_CNT_W-1:0] divLast;
  logic [CNT_W-1:0]     cntQ;
  logic [PULSE_W-1:0]   pulseQ;
  logic preTick, tick;

  always_comb divLast = DIV_CNT_W'((BASE_DIV << cmd.divSel) - 1);

  assign preTick = cmd.run && (preCnt == cmd.prescale);
  assign tick    = preTick && (divCnt == divLast);
  assign expire  = tick && (cntQ == '0) && !cmd.loadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (!cmd.run) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (preTick) begin
      preCnt <= '0;
      divCnt <= (divCnt == divLast) ? '0 : divCnt + DIV_CNT_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= CNT_RESET;
    else if (cmd.loadCnt) cntQ <= cmd.loadVal;
    else if (expire)      cntQ <= cmd.reload;
    else if (tick)        cntQ <= cntQ - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    pulseQ <= '0;
    else if (expire && cmd.rstEn) pulseQ <= PULSE_W'(PULSE_LEN);
    else if (pulseQ != '0)        pulseQ <= pulseQ - PULSE_W'(1);
  end

  assign count    = cntQ;
  assign resetReq = (pulseQ != '0) && cmd.rstEn;

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.loadCnt) |=> $stable(cntQ)); // R6
  AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cntQ == $past(cmd.reload))); // R4
  AST_KEEPALIVE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadCnt |=> (cntQ == $past(cmd.loadVal))); // R5
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !expire && !cmd.loadCnt) |=> (cntQ == $past(cntQ) - CNT_W'(1))); // R3
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ != '0) |-> $past(expire && cmd.rstEn)); // R9
endmodule

// File: rtl/pwdog_top.sv
module pwdog_top
  import pwdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              resetReq
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] count;
  logic             expire;

  pwdog_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .expire(expire),
    .count(count), .cmd(cmd), .irq(irq)
  );

  pwdog_datapath i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count),
    .expire(expire), .resetReq(resetReq)
  );
endmodule

// File: tb/test_pwdog_top.sv
module test_pwdog_top;
  localparam logic [3:0] A_CTRL = 4'h0, A_RELOAD = 4'h4, A_COUNT = 4'h8, A_ICLR = 4'hC;

  logic clk = 1'b0, rstN = 1'b0, busWe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic irq, resetReq;
  int nChecks = 0, nFails = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  pwdog_top i_pwdog_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .resetReq(resetReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(A_CTRL, rv);   check("R1 ctrl", rv, 16'h8021);
    rd(A_RELOAD, rv); check("R1 reload", rv, 16'h8000);
    rd(A_COUNT, rv);  check("R1 count", rv, 16'h8000);
    check("R1 irq", irq, 0);
    check("R1 resetReq", resetReq, 0);
    // R2 map and masking
    rd(A_ICLR, rv);   check("R2 iclr reads 0", rv, 0);
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, rv);   check("R2 ctrl mask", rv, 16'hFF3D);
    wr(A_CTRL, 16'h0000);
    wr(A_RELOAD, 16'hA5C3);
    rd(A_RELOAD, rv); check("R2 reload rw", rv, 16'hA5C3);
    wr(A_COUNT, 16'h1234);
    rd(A_COUNT, rv);  check("R5 direct count load", rv, 16'h1234);

    // R3/R4 sweep over prescale, divide select and start count
    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 4; d++)
        for (int n = 0; n < 3; n++) begin
          int ex;
          wr(A_CTRL, 16'h0000);
          wr(A_ICLR, 16'h0001);
          wr(A_RELOAD, 16'd5);
          wr(A_COUNT, 16'(n));
          wr(A_CTRL, 16'(16'h0024 | (d << 3) | (p << 8)));
          ex = (n + 1) * (p + 1) * (16 << d);
          repeat (ex - 1) @(negedge clk);
          check($sformatf("R3 no early expiry p=%0d d=%0d n=%0d", p, d, n), irq, 0);
          @(negedge clk);
          check($sformatf("R3 expiry edge p=%0d d=%0d n=%0d", p, d, n), irq, 1);
          rd(A_COUNT, rv);
          check("R4 reload after expiry", rv, 16'd5);
        end

    // R5 keep-alive
    wr(A_CTRL, 16'h0000); wr(A_ICLR, 16'h0001);
    wr(A_COUNT, 16'd3); wr(A_CTRL, 16'h0024);
    for (int k = 0; k < 10; k++) begin
      repeat (38) @(negedge clk);
      wr(A_COUNT, 16'd3);
    end
    check("R5 kept alive", irq, 0);
    repeat (70) @(negedge clk);
    check("R5 expires once writes stop", irq, 1);

    // R6 stop holds counter
    wr(A_CTRL, 16'h0000); wr(A_ICLR, 16'h0001);
    wr(A_COUNT, 16'd10); wr(A_CTRL, 16'h0020);
    repeat (40) @(negedge clk);
    wr(A_CTRL, 16'h0000);
    rd(A_COUNT, rv); check("R6 count at stop", rv, 16'd8);
    repeat (200) @(negedge clk);
    rd(A_COUNT, rv); check("R6 count held", rv, 16'd8);

    // R7 gating and clear
    wr(A_RELOAD, 16'd100); wr(A_COUNT, 16'd0); wr(A_CTRL, 16'h0024);
    repeat (20) @(negedge clk);
    check("R7 flag raised", irq, 1);
    wr(A_CTRL, 16'h0020); check("R7 gated off", irq, 0);
    wr(A_CTRL, 16'h0024); check("R7 pending returns", irq, 1);
    wr(A_ICLR, 16'h0000); check("R7 write 0 no clear", irq, 1);
    wr(A_ICLR, 16'h0001); check("R7 clear", irq, 0);

    // R8 no flag without interrupt enable
    wr(A_CTRL, 16'h0000); wr(A_COUNT, 16'd0); wr(A_CTRL, 16'h0020);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 16'h0024);
    check("R8 no flag latched", irq, 0);
    check("R9 no pulse without rstEn", resetReq, 0);

    // R9 reset pulse length
    wr(A_CTRL, 16'h0000); wr(A_COUNT, 16'd0); wr(A_CTRL, 16'h0021);
    repeat (15) @(negedge clk);
    check("R9 before expiry", resetReq, 0);
    @(negedge clk);
    check("R9 pulse start", resetReq, 1);
    repeat (127) @(negedge clk);
    check("R9 pulse last cycle", resetReq, 1);
    @(negedge clk);
    check("R9 pulse end", resetReq, 0);
    wr(A_CTRL, 16'h0000); wr(A_COUNT, 16'd0); wr(A_CTRL, 16'h0021);
    repeat (20) @(negedge clk);
    check("R9 pulse active", resetReq, 1);
    wr(A_CTRL, 16'h0020);
    check("R9 suppressed by rstEn clear", resetReq, 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule